// File: doc/BRIEF.md
# Stepper Motor Phase Sequencer

This block turns a stream of internally timed step events into winding drive patterns for a small stepper motor. A phase index moves one position per step, forward or backward, and a pattern stage maps that index to the four winding outputs. The mapping depends on the drive mode.

Four drive modes share the one index machine:

- a three-winding variable reluctance sequence;
- single-coil wave drive on a unipolar motor;
- two-coil full-step drive on a unipolar motor;
- an eight-state half-step drive, which alternates between the single-coil and two-coil patterns.

Step events come from a built-in rate divider. It fires once every `rate_div` clock cycles while the block is enabled. Software picks a speed from the relation steps-per-second = RPM × steps-per-revolution / 60. It then writes the clock frequency divided by that rate as the divisor.

The winding outputs are ordered `{W2b, W1b, W2a, W1a}` from bit 3 down to bit 0. In variable reluctance mode, windings 1, 2 and 3 sit on bits 0, 1 and 2, and bit 3 stays low. When the block is disabled the index is frozen, so the motor keeps the last pattern and its holding torque.

Top module: `stepper_phase_seq`

## Requirements
- R1: During synchronous reset (rst_n low at a rising edge), the phase index returns to 0, the divider count is cleared, and the mode input is captured. After reset the winding output shows the first pattern of that mode.
- R2: Mode code 0 (variable reluctance) has three states. They drive winding hex 1, 2, 4 for indices 0, 1, 2, and bit 3 is always 0.
- R3: Mode code 1 (wave) has four states. They drive winding hex 1, 2, 4, 8 for indices 0 to 3, which is W1a, W2a, W1b, W2b.
- R4: Mode code 2 (two-coil full step) has four states. They drive winding hex 9, 3, 6, C for indices 0 to 3, so exactly two windings are on.
- R5: Mode code 3 (half step) has eight states. They drive winding hex 1, 3, 2, 6, 4, C, 8, 9 for indices 0 to 7.
- R6: On a step, dir=0 increments the index and dir=1 decrements it. The index wraps modulo the current mode's sequence length (3, 4, 4 or 8).
- R7: With en high and a nonzero divisor D, a step takes effect at the D-th rising edge after the divider starts from a cleared count. Steps then repeat every D edges.
- R8: A divisor of 0 produces no steps; the winding output does not change while the mode is unchanged.
- R9: While en is low, the index does not move and the divider count is held cleared, so the winding output keeps its last pattern.
- R10: A change of the mode input resets the index to 0 at the next rising edge. This takes priority over a step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Allows stepping; low holds the current pattern |
| dir | input | 1 | 0 steps forward, 1 steps backward |
| mode | input | 2 | Drive mode: 0 reluctance, 1 wave, 2 full step, 3 half step |
| rate_div | input | DIV_W (16) | Clock cycles per step; 0 disables stepping |
| winding | output | 4 | Winding drive {W2b, W1b, W2a, W1a} |

## Verification
The bench sweeps every drive mode in both directions through two full electrical cycles. The expected pattern comes from shift arithmetic. Running twice round the sequence shows both the wrap point and the table content. Running it in reverse separates a correct decrement from a mirrored table.

With a divisor of 3, each step is checked to be absent after two edges and present after the third. This distinguishes an off-by-one divider from a correct one. Further runs cover four cases:

- a divisor of 1, where a step lands on every edge;
- a divisor of 0 with the block enabled;
- a disabled block holding its pattern;
- a mode change during active stepping, which must land on index 0 rather than advance.

// File: rtl/stp_pkg.sv
// Shared types and helpers for the stepper phase sequencer.
// Assumes at most eight phase states in any drive mode.
package stp_pkg;
    localparam int WIND_W = 4;
    localparam int IDX_W  = 3;

    typedef enum logic [1:0] {
        DRV_VR   = 2'd0,
        DRV_WAVE = 2'd1,
        DRV_FULL = 2'd2,
        DRV_HALF = 2'd3
    } drive_mode_e;

    // Highest valid phase index for a drive mode (sequence length minus one).
    function automatic logic [IDX_W-1:0] seq_last(drive_mode_e m);
        case (m)
            DRV_VR:   seq_last = IDX_W'(2);
            DRV_WAVE: seq_last = IDX_W'(3);
            DRV_FULL: seq_last = IDX_W'(3);
            default:  seq_last = IDX_W'(7);
        endcase
    endfunction
endpackage

// File: rtl/stp_rate_div.sv
// Step rate divider: pulses tick for one cycle every 'divisor' cycles while
// enabled. Assumes divisor may change at any time; a count already past the
// new limit fires at once. Divisor 0 or en low clears the count.
module stp_rate_div #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic             run;

    // Decide whether the divider is running and whether this cycle ends a period.
    always_comb begin
        run  = en && (divisor != '0);
        tick = run && (cnt_q >= (divisor - DIV_W'(1)));
    end

    // Count clock cycles within the current step period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/stp_index.sv
// Phase index machine: keeps the registered drive mode and a phase index.
// A mode change clears the index; otherwise a tick moves it one place in
// the chosen direction, wrapping at the mode's sequence length.
module stp_index
    import stp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  drive_mode_e      mode_in,
    input  logic             tick,
    input  logic             dir,
    output drive_mode_e      mode_q,
    output logic [IDX_W-1:0] idx_q
);
    logic [IDX_W-1:0] last;
    logic [IDX_W-1:0] idx_fwd;
    logic [IDX_W-1:0] idx_rev;

    // Work out the wrapped neighbours of the current index.
    always_comb begin
        last    = seq_last(mode_q);
        idx_fwd = (idx_q == last)  ? '0   : idx_q + IDX_W'(1);
        idx_rev = (idx_q == '0)    ? last : idx_q - IDX_W'(1);
    end

    // Track the mode and update the index, mode change first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= mode_in;
            idx_q  <= '0;
        end else if (mode_in != mode_q) begin
            mode_q <= mode_in;
            idx_q  <= '0;
        end else if (tick) begin
            idx_q  <= dir ? idx_rev : idx_fwd;
        end
    end
endmodule

// File: rtl/stp_pattern.sv
// Winding pattern map: converts mode and phase index to the four winding
// drives {W2b, W1b, W2a, W1a}. Purely combinational; assumes idx is in range.
module stp_pattern
    import stp_pkg::*;
(
    input  drive_mode_e       mode,
    input  logic [IDX_W-1:0]  idx,
    output logic [WIND_W-1:0] winding
);
    logic [WIND_W-1:0] single_coil;
    logic [WIND_W-1:0] dual_coil;
    logic [1:0]        quad;

    // Build one-coil and two-coil shapes by rotation of a base pattern.
    always_comb begin
        quad        = idx[1:0];
        single_coil = WIND_W'(1) << quad;
        dual_coil   = (4'b1001 << quad) | (4'b1001 >> (WIND_W - int'(quad)));
    end

    // Select the shape for the active drive mode.
    always_comb begin
        case (mode)
            DRV_VR:   winding = (idx < IDX_W'(3)) ? (WIND_W'(1) << idx[1:0]) : '0;
            DRV_WAVE: winding = single_coil;
            DRV_FULL: winding = dual_coil;
            default: begin
                winding = WIND_W'(1) << idx[2:1];
                if (idx[0]) begin
                    winding = winding | (WIND_W'(1) << (idx[2:1] + 2'd1));
                end
            end
        endcase
    end
endmodule

// File: rtl/stepper_phase_seq.sv
// Stepper motor phase sequencer top: rate divider -> index machine ->
// pattern map. Assumes the mode input is a registered control value.
module stepper_phase_seq
    import stp_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             dir,
    input  logic [1:0]       mode,
    input  logic [DIV_W-1:0] rate_div,
    output logic [3:0]       winding
);
    logic              step_tick;
    drive_mode_e       mode_q;
    logic [IDX_W-1:0]  idx;

    stp_rate_div #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .divisor (rate_div),
        .tick    (step_tick)
    );

    stp_index u_idx (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_in (drive_mode_e'(mode)),
        .tick    (step_tick),
        .dir     (dir),
        .mode_q  (mode_q),
        .idx_q   (idx)
    );

    stp_pattern u_pat (
        .mode    (mode_q),
        .idx     (idx),
        .winding (winding)
    );
endmodule

// File: rtl/stp_seq_checker.sv
// Property checker for the stepper phase sequencer, bound to the top.
module stp_seq_checker
    import stp_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic [1:0]       mode,
    input logic [15:0]      rate_div,
    input logic [3:0]       winding,
    input drive_mode_e      mode_q,
    input logic [IDX_W-1:0] idx,
    input logic             tick
);
    a_r8_no_step_div0: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_div == '0 && drive_mode_e'(mode) == mode_q) |=> $stable(winding));

    a_r9_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && drive_mode_e'(mode) == mode_q) |=> $stable(winding));

    a_r10_mode_clears_idx: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_mode_e'(mode) != mode_q) |=> (idx == '0));

    a_r6_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= seq_last(mode_q));

    a_r2_vr_single: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == DRV_VR) |-> (!winding[3] && $countones(winding) == 1));

    a_r4_full_two_coils: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == DRV_FULL) |-> ($countones(winding) == 2));

    a_r7_tick_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (en && rate_div != '0));
endmodule

bind stepper_phase_seq stp_seq_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .mode     (mode),
    .rate_div (rate_div),
    .winding  (winding),
    .mode_q   (mode_q),
    .idx      (idx),
    .tick     (step_tick)
);

// File: tb/tb_stepper_phase_seq.sv
module tb_stepper_phase_seq;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        dir = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [15:0] rate_div = 16'd0;
    logic [3:0]  winding;
    int          n_checks = 0;
    int          n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stepper_phase_seq dut (
        .clk(clk), .rst_n(rst_n), .en(en), .dir(dir),
        .mode(mode), .rate_div(rate_div), .winding(winding)
    );

    function automatic int seq_len(int m);
        return (m == 0) ? 3 : (m == 3) ? 8 : 4;
    endfunction

    // Expected pattern, computed arithmetically from R2..R5.
    function automatic logic [3:0] pat(int m, int i);
        int r;
        case (m)
            0, 1: r = 1 << i;
            2:    r = ((9 << i) | (9 >> (4 - i))) & 15;
            default: begin
                r = 1 << (i / 2);
                if (i % 2 == 1) r = r | (1 << ((i / 2 + 1) % 4));
            end
        endcase
        return 4'(r);
    endfunction

    task automatic chk(logic [3:0] exp, string req);
        n_checks++;
        if (winding !== exp) begin
            n_errors++;
            $display("FAIL %s: winding=%h expected=%h", req, winding, exp);
        end
    endtask

    task automatic edges(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [3:0] held;
        edges(3);
        rst_n = 1'b1;
        edges(1);
        chk(pat(0, 0), "R1");
        // Sweep all modes and both directions with divisor 3.
        for (int m = 0; m < 4; m++) begin
            for (int d = 0; d < 2; d++) begin
                int i;
                string rq;
                rq = (m == 0) ? "R2" : (m == 1) ? "R3" : (m == 2) ? "R4" : "R5";
                en = 1'b0; mode = 2'(m); dir = d[0]; rate_div = 16'd3;
                mode = 2'((m + 1) % 4);
                edges(1);
                mode = 2'(m);
                edges(2);
                chk(pat(m, 0), "R10");
                en = 1'b1;
                i = 0;
                for (int s = 0; s < 2 * seq_len(m); s++) begin
                    edges(2);
                    chk(pat(m, i), "R7");
                    edges(1);
                    i = d ? (i + seq_len(m) - 1) % seq_len(m) : (i + 1) % seq_len(m);
                    chk(pat(m, i), d ? "R6" : rq);
                end
                en = 1'b0;
            end
        end
        // Divisor 1: a step on every edge (half-step mode, forward).
        mode = 2'd2; edges(1); mode = 2'd3; dir = 1'b0; rate_div = 16'd1;
        edges(1);
        en = 1'b1;
        for (int s = 1; s <= 3; s++) begin
            edges(1);
            chk(pat(3, s), "R7");
        end
        // Disabled: pattern holds.
        en = 1'b0;
        held = winding;
        for (int s = 0; s < 8; s++) begin
            edges(1);
            chk(held, "R9");
        end
        // Divisor 0 while enabled: no stepping.
        en = 1'b1; rate_div = 16'd0;
        for (int s = 0; s < 8; s++) begin
            edges(1);
            chk(held, "R8");
        end
        // Mode change while stepping every cycle: index goes to 0 first.
        rate_div = 16'd1;
        edges(1);
        chk(pat(3, 4), "R7");
        mode = 2'd2;
        edges(1);
        chk(pat(2, 0), "R10");
        edges(1);
        chk(pat(2, 1), "R4");
        // Reset returns to first pattern of the captured mode.
        rst_n = 1'b0; mode = 2'd1;
        edges(1);
        rst_n = 1'b1;
        chk(pat(1, 0), "R1");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule